// File: doc/BRIEF.md
# Pulse-Swallow Feedback and Reference Divider

This block forms the two divided frequencies that a phase comparator needs in a synthesizer loop. On the feedback side, a swallow counter and a main counter drive a two-modulus prescaler. The swallow counter holds the prescaler at M+1 for the first A prescaler cycles of each output period and at M for the remaining ones. The feedback pulse `fp` therefore arrives once every M*N+A cycles of the oscillator-rate input. The base modulus M is chosen between a small and a large value by one select input. On the reference side, an independent counter divides the reference oscillator clock by R and emits `fr`.

A counter model of the prescaler is built in, so the whole feedback path runs on the input clock `vco_clk`. The prescaler's output appears as an internal one-cycle tick, and the swallow and main counters advance on that tick. The divide settings are taken as already-latched inputs. The block samples them only when a counter reloads, so an output period that is in progress always completes with the ratio it began with.

Top module: `pswallow_divider`

## Requirements
- R1: With 5 <= N <= 2047 (11-bit binary `cfg_n`) and 0 <= A < N (7-bit binary `cfg_a`), consecutive `fp` pulses are exactly M*N+A `vco_clk` cycles apart.
- R2: `cfg_sel_small` = 1 selects M = PRE_SMALL (64 by default), and `cfg_sel_small` = 0 selects M = PRE_LARGE (128 by default).
- R3: In each feedback period `mod_hi` is high for the first A prescaler cycles, which is A*(M+1) `vco_clk` cycles counted from the cycle in which `fp` is high, and low for the remainder of the period.
- R4: When A = 0, `mod_hi` stays low for the whole period.
- R5: With 5 <= R <= 16383 (14-bit binary `cfg_r`), consecutive `fr` pulses are exactly R `ref_clk` cycles apart.
- R6: `fp` is high for exactly one `vco_clk` cycle per pulse, and `fr` is high for exactly one `ref_clk` cycle per pulse.
- R7: A change of `cfg_n`, `cfg_a` or `cfg_sel_small` during a feedback period leaves that period's length unchanged. The new ratio applies from the following period.
- R8: A change of `cfg_r` during a reference period leaves that period's length unchanged. The new ratio applies from the following period.
- R9: While the reset inputs are low, `fp`, `fr` and `mod_hi` are low.
- R10: The extreme settings N = 2047 with A = 127, and R = 16383, give exact ratios.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk | input | 1 | Oscillator-rate input clock (prescaler input) |
| vco_rst_n | input | 1 | Asynchronous active-low reset, vco_clk domain |
| ref_clk | input | 1 | Reference oscillator clock |
| ref_rst_n | input | 1 | Asynchronous active-low reset, ref_clk domain |
| cfg_n | input | N_W | Main counter setting N |
| cfg_a | input | A_W | Swallow counter setting A |
| cfg_sel_small | input | 1 | 1: small modulus pair, 0: large modulus pair |
| cfg_r | input | R_W | Reference divide setting R |
| mod_hi | output | 1 | Modulus control, 1 = prescaler divides by M+1 |
| fp | output | 1 | Divided feedback pulse, vco_clk domain |
| fr | output | 1 | Divided reference pulse, ref_clk domain |

## Verification
The assertions assume that every setting sampled at a reload is legal: N of at least 5, A strictly below N, and R of at least 5. Settings below 5 are prohibited, and the pulse-width and swallow properties do not hold for them. The stimulus changes the settings only as one legal combination, written right after a pulse is seen, and it sweeps A only over 0..N-1. The bench shrinks the prescaler moduli to 4 and 8. This lets it sweep every legal (N, A) pair for small N under both moduli and still cover the widest N and R.

// File: rtl/psd_pkg.sv
package psd_pkg;

  // Length in input cycles of one prescaler output cycle.
  function automatic int unsigned prescale_len(input logic hi, input logic sel_small,
                                               input int unsigned m_small,
                                               input int unsigned m_large);
    int unsigned m;
    m = sel_small ? m_small : m_large;
    return hi ? m + 1 : m;
  endfunction

  // Input cycles per feedback pulse for modulus m, main count n, swallow count a.
  function automatic int unsigned feedback_ratio(input int unsigned m, input int unsigned n,
                                                 input int unsigned a);
    return m * n + a;
  endfunction

endpackage

// File: rtl/psd_prescaler.sv
module psd_prescaler #(
  parameter int unsigned PRE_SMALL = 64,
  parameter int unsigned PRE_LARGE = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic next_hi,
  input  logic next_sel_small,
  output logic tick
);
  import psd_pkg::*;
  localparam int unsigned PC_W = $clog2(PRE_LARGE + 1);

  logic [PC_W-1:0] pc;

  assign tick = (pc == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc <= '0;
    else if (tick)
      pc <= PC_W'(prescale_len(next_hi, next_sel_small, PRE_SMALL, PRE_LARGE) - 1);
    else pc <= pc - PC_W'(1);
  end

  // R1: a prescaler cycle spans at least two input cycles
  p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n) tick |=> !tick);

endmodule

// File: rtl/psd_swallow_ctrl.sv
module psd_swallow_ctrl #(
  parameter int unsigned N_W = 11,
  parameter int unsigned A_W = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic [N_W-1:0] cfg_n,
  input  logic [A_W-1:0] cfg_a,
  input  logic           cfg_sel_small,
  output logic           next_hi,
  output logic           next_sel_small,
  output logic           mod_hi,
  output logic           fp
);
  logic [N_W-1:0] n_rem;
  logic [A_W-1:0] a_rem;
  logic [A_W-1:0] a_dec;
  logic [A_W-1:0] next_a;
  logic           sel_act;
  logic           period_end;
  logic           reload;

  assign period_end     = tick && (n_rem == N_W'(1));
  assign reload         = tick && (n_rem <= N_W'(1));
  assign a_dec          = (a_rem != '0) ? a_rem - A_W'(1) : '0;
  assign next_a         = reload ? cfg_a : a_dec;
  assign next_hi        = (next_a != '0);
  assign next_sel_small = reload ? cfg_sel_small : sel_act;
  assign mod_hi         = (a_rem != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_rem   <= '0;
      a_rem   <= '0;
      sel_act <= 1'b0;
      fp      <= 1'b0;
    end else begin
      fp <= period_end;
      if (tick) begin
        n_rem   <= reload ? cfg_n : n_rem - N_W'(1);
        a_rem   <= next_a;
        sel_act <= next_sel_small;
      end
    end
  end

  // R1: settings sampled at a reload are legal (input assumption)
  p_cfg_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    reload |-> (cfg_n >= N_W'(5)) && (N_W'(cfg_a) < cfg_n));
  // R6: feedback pulse lasts one cycle
  p_fp_single_r6: assert property (@(posedge clk) disable iff (!rst_n) fp |=> !fp);
  // R3: modulus control only drops at a prescaler boundary
  p_mod_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mod_hi) |-> $past(tick));
  // R4: a zero swallow count keeps the modulus low from the reload on
  p_a_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reload && cfg_a == '0) |=> !mod_hi);
  // R3: a nonzero swallow count raises the modulus at the reload
  p_a_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reload && cfg_a != '0) |=> mod_hi);

endmodule

// File: rtl/psd_ref_div.sv
module psd_ref_div #(
  parameter int unsigned R_W = 14
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [R_W-1:0] cfg_r,
  output logic           fr
);
  logic [R_W-1:0] r_rem;
  logic           ref_end;
  logic           ref_reload;

  assign ref_end    = (r_rem == R_W'(1));
  assign ref_reload = (r_rem <= R_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_rem <= '0;
      fr    <= 1'b0;
    end else begin
      fr    <= ref_end;
      r_rem <= ref_reload ? cfg_r : r_rem - R_W'(1);
    end
  end

  // R5: reference setting legal at reload (input assumption)
  p_r_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ref_reload |-> cfg_r >= R_W'(5));
  // R6: reference pulse lasts one cycle
  p_fr_single_r6: assert property (@(posedge clk) disable iff (!rst_n) fr |=> !fr);

endmodule

// File: rtl/pswallow_divider.sv
module pswallow_divider #(
  parameter int unsigned N_W       = 11,
  parameter int unsigned A_W       = 7,
  parameter int unsigned R_W       = 14,
  parameter int unsigned PRE_SMALL = 64,
  parameter int unsigned PRE_LARGE = 128
) (
  input  logic           vco_clk,
  input  logic           vco_rst_n,
  input  logic           ref_clk,
  input  logic           ref_rst_n,
  input  logic [N_W-1:0] cfg_n,
  input  logic [A_W-1:0] cfg_a,
  input  logic           cfg_sel_small,
  input  logic [R_W-1:0] cfg_r,
  output logic           mod_hi,
  output logic           fp,
  output logic           fr
);
  logic tick;
  logic next_hi;
  logic next_sel_small;

  psd_prescaler #(.PRE_SMALL(PRE_SMALL), .PRE_LARGE(PRE_LARGE)) u_pre (
    .clk(vco_clk), .rst_n(vco_rst_n), .next_hi(next_hi),
    .next_sel_small(next_sel_small), .tick(tick));

  psd_swallow_ctrl #(.N_W(N_W), .A_W(A_W)) u_ctrl (
    .clk(vco_clk), .rst_n(vco_rst_n), .tick(tick), .cfg_n(cfg_n), .cfg_a(cfg_a),
    .cfg_sel_small(cfg_sel_small), .next_hi(next_hi), .next_sel_small(next_sel_small),
    .mod_hi(mod_hi), .fp(fp));

  psd_ref_div #(.R_W(R_W)) u_ref (
    .clk(ref_clk), .rst_n(ref_rst_n), .cfg_r(cfg_r), .fr(fr));

  // R9: outputs quiet during reset
  always_comb begin
    if (!vco_rst_n) p_rst_quiet_r9: assert (!fp && !mod_hi);
  end

endmodule

// File: tb/pswallow_divider_tb.sv
module pswallow_divider_tb;
  localparam int unsigned M_S = 4;
  localparam int unsigned M_L = 8;

  logic        vco_clk = 1'b0;
  logic        ref_clk = 1'b0;
  logic        vco_rst_n = 1'b0;
  logic        ref_rst_n = 1'b0;
  logic [10:0] cfg_n = 11'd5;
  logic [6:0]  cfg_a = 7'd0;
  logic        cfg_sel_small = 1'b1;
  logic [13:0] cfg_r = 14'd5;
  logic        mod_hi, fp, fr;

  int tests = 0;
  int fails = 0;
  int wide_fp = 0;
  int wide_fr = 0;
  logic fp_last = 1'b0;
  logic fr_last = 1'b0;

  always #2 vco_clk = ~vco_clk;
  initial begin #1; forever #2 ref_clk = ~ref_clk; end

  pswallow_divider #(.PRE_SMALL(M_S), .PRE_LARGE(M_L)) u_dut (
    .vco_clk(vco_clk), .vco_rst_n(vco_rst_n), .ref_clk(ref_clk), .ref_rst_n(ref_rst_n),
    .cfg_n(cfg_n), .cfg_a(cfg_a), .cfg_sel_small(cfg_sel_small), .cfg_r(cfg_r),
    .mod_hi(mod_hi), .fp(fp), .fr(fr));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge vco_clk) begin
    if (vco_rst_n && fp && fp_last) wide_fp++;
    fp_last = fp;
  end
  always @(negedge ref_clk) begin
    if (ref_rst_n && fr && fr_last) wide_fr++;
    fr_last = fr;
  end

  // Starting at a negedge where fp is high, count to the next fp.
  task automatic meas_fp(output int len, output int hi);
    len = 0; hi = 0;
    do begin
      if (mod_hi) hi++;
      len++;
      @(negedge vco_clk);
    end while (!fp);
  endtask

  task automatic meas_fr(output int len);
    len = 0;
    do begin len++; @(negedge ref_clk); end while (!fr);
  endtask

  task automatic step_fb(input bit sel, input int n, input int a,
                         input int old_ratio, output int new_ratio);
    int len, hi, m;
    m = sel ? M_S : M_L;
    new_ratio = m * n + a;
    cfg_sel_small = sel; cfg_n = 11'(n); cfg_a = 7'(a);
    meas_fp(len, hi);
    chk(len == old_ratio, "R7 period in progress keeps old ratio", len, old_ratio);
    meas_fp(len, hi);
    chk(len == new_ratio, (n == 2047) ? "R10 R1 R2 extreme feedback ratio" : "R1 R2 feedback ratio",
        len, new_ratio);
    chk(hi == a * (m + 1), (a == 0) ? "R4 mod_hi low when A is 0" : "R3 mod_hi span",
        hi, a * (m + 1));
  endtask

  task automatic run_fb();
    int cur;
    cur = M_S * 5;
    do @(negedge vco_clk); while (!fp);
    for (int s = 0; s < 2; s++)
      for (int n = 5; n <= 12; n++)
        for (int a = 0; a < n; a++)
          step_fb(s == 0, n, a, cur, cur);
    step_fb(1'b0, 2047, 127, cur, cur);
  endtask

  task automatic step_ref(input int r, input int old_r);
    int len;
    cfg_r = 14'(r);
    meas_fr(len);
    chk(len == old_r, "R8 reference period in progress keeps old ratio", len, old_r);
    meas_fr(len);
    chk(len == r, (r == 16383) ? "R10 R5 extreme reference ratio" : "R5 reference ratio", len, r);
  endtask

  task automatic run_ref();
    int cur;
    cur = 5;
    do @(negedge ref_clk); while (!fr);
    for (int r = 5; r <= 40; r++) begin step_ref(r, cur); cur = r; end
    step_ref(16383, cur);
  endtask

  initial begin
    repeat (200000) @(posedge vco_clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge vco_clk);
    chk(!fp, "R9 fp low in reset", int'(fp), 0);
    chk(!fr, "R9 fr low in reset", int'(fr), 0);
    chk(!mod_hi, "R9 mod_hi low in reset", int'(mod_hi), 0);
    vco_rst_n = 1'b1;
    ref_rst_n = 1'b1;
    fork
      run_fb();
      run_ref();
    join
    chk(wide_fp == 0, "R6 fp one cycle wide", wide_fp, 0);
    chk(wide_fr == 0, "R6 fr one cycle wide", wide_fr, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule